// File: doc/BRIEF.md
# Extended-state restore fault checker

This block decides, in a single combinational pass, whether a restore of extended processor state from a memory save area may go ahead. It looks at all of the following before any architectural state is touched:

- the linear address of the operand;
- the 64-byte header of the save area;
- the enabled-features mask;
- the two capability bits, for save support and compacted-form support;
- the OS enable bit;
- the task-switched bit;
- a lock-prefix flag;
- the candidate control/status word, together with its mask of reserved bits.

It answers with a one-hot fault class and a numeric cause index. The execution pipeline uses these to either proceed or take the fault.

The header is read as 64 bytes. Byte k sits at bits 8k+7 down to 8k. The state-present bitmap is bytes 0 to 7, little-endian, so it is bits 63:0. The compaction bitmap is bytes 8 to 15, which is bits 127:64. Bit 63 of the compaction bitmap selects the form: 0 is standard and 1 is compacted. The validity rules for the header differ between the two forms.

Top module: `rstr_fault_check`

## Requirements
- R1: fault_o is always one-hot. Its encodings are: none 4'b0001, general-protection 4'b0010, undefined-opcode 4'b0100, device-not-available 4'b1000. cause_o is 0 exactly when the class is none.
- R2: An undefined-opcode fault is raised when cap_save_i is 0 (cause 1), when os_en_i is 0 (cause 2), or when lock_i is 1 (cause 3). When several of these apply, the lowest cause number is reported. This fault ranks above every other fault.
- R3: When no undefined-opcode cause applies and task_sw_i is 1, the result is a device-not-available fault with cause 4. It ranks above every general-protection cause.
- R4: General-protection causes are reported only when no undefined-opcode or device-not-available cause applies. Among them the lowest cause number, from 5 to 12, wins.
- R5: An address whose low 6 bits are not all zero gives general-protection cause 5.
- R6: Compaction bitmap bit 63 set while cap_cmp_i is 0 gives cause 6.
- R7: In standard form, a state-present bit that is set where the enabled-features bit is clear gives cause 7.
- R8: In standard form, any nonzero bit in header bytes 8 to 23 gives cause 8.
- R9: In compacted form, a set compaction bit among bits 0 to 62 whose enabled-features bit is clear gives cause 9.
- R10: In compacted form, a state-present bit that is set where the compaction bit is clear gives cause 10.
- R11: In compacted form, any nonzero bit in header bytes 16 to 63 gives cause 11.
- R12: When csw_i AND csw_rsvd_i is nonzero, the result is cause 12.
- R13: When none of the conditions above holds, the result is the none class with cause 0. This holds in either form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | ADDR_W | Linear address of the save area |
| hdr_i | input | 512 | Save-area header, byte k at bits 8k+7:8k |
| feat_en_i | input | FEAT_W | Enabled-features mask |
| cap_save_i | input | 1 | Save/restore feature is present |
| cap_cmp_i | input | 1 | Compacted form is supported |
| os_en_i | input | 1 | OS has enabled the feature |
| task_sw_i | input | 1 | Task-switched bit |
| lock_i | input | 1 | Lock prefix present |
| csw_i | input | CSW_W | Candidate control/status word |
| csw_rsvd_i | input | CSW_W | Reserved-bit mask of that word |
| fault_o | output | 4 | One-hot fault class |
| cause_o | output | 4 | Cause index |

## Verification
The interesting collisions are those in which several fault conditions hold for the same operand. Examples are a misaligned address paired with a bad header, a set task-switched bit paired with a lock prefix, or a header that breaks two rules of its form at once. Directed cases stack such conditions two and three deep. Biased random headers then mix aligned and misaligned addresses with valid and corrupted bitmaps. Each result is judged against a bench model that walks the causes in priority order. The bench checks that only the highest-ranked class and cause appear.

// File: rtl/rstr_fault_pkg.sv
package rstr_fault_pkg;
   localparam int HDR_BYTES = 64;
   localparam int HDR_BITS  = HDR_BYTES * 8;
   localparam int CAUSE_W   = 4;

   typedef enum logic [3:0] {
      FLT_NONE = 4'b0001,
      FLT_GP   = 4'b0010,
      FLT_UD   = 4'b0100,
      FLT_NM   = 4'b1000
   } fault_e;

   localparam logic [CAUSE_W-1:0] C_NONE      = 4'd0;
   localparam logic [CAUSE_W-1:0] C_UD_NOCAP  = 4'd1;
   localparam logic [CAUSE_W-1:0] C_UD_NOOS   = 4'd2;
   localparam logic [CAUSE_W-1:0] C_UD_LOCK   = 4'd3;
   localparam logic [CAUSE_W-1:0] C_NM_TS     = 4'd4;
   localparam logic [CAUSE_W-1:0] C_GP_ALIGN  = 4'd5;
   localparam logic [CAUSE_W-1:0] C_GP_NOCMP  = 4'd6;
   localparam logic [CAUSE_W-1:0] C_GP_SPRES  = 4'd7;
   localparam logic [CAUSE_W-1:0] C_GP_SRSV   = 4'd8;
   localparam logic [CAUSE_W-1:0] C_GP_CBIT   = 4'd9;
   localparam logic [CAUSE_W-1:0] C_GP_CORPH  = 4'd10;
   localparam logic [CAUSE_W-1:0] C_GP_CRSV   = 4'd11;
   localparam logic [CAUSE_W-1:0] C_GP_CSW    = 4'd12;

   // header rule flags, index order is GP priority order (after alignment)
   localparam int NHF = 6;
   typedef struct packed {
      logic crsv;
      logic corph;
      logic cbit;
      logic srsv;
      logic spres;
      logic nocmp;
   } hdr_flags_t;
endpackage

// File: rtl/rsc_access_check.sv
module rsc_access_check
   import rstr_fault_pkg::*;
(
   input  logic               cap_save_i,
   input  logic               os_en_i,
   input  logic               lock_i,
   input  logic               task_sw_i,
   output logic               ud_o,
   output logic [CAUSE_W-1:0] ud_cause_o,
   output logic               nm_o
);
   always_comb begin
      ud_o       = 1'b1;
      ud_cause_o = C_NONE;
      if (!cap_save_i)   ud_cause_o = C_UD_NOCAP;
      else if (!os_en_i) ud_cause_o = C_UD_NOOS;
      else if (lock_i)   ud_cause_o = C_UD_LOCK;
      else               ud_o       = 1'b0;
   end

   assign nm_o = task_sw_i;
endmodule

// File: rtl/rsc_header_check.sv
module rsc_header_check
   import rstr_fault_pkg::*;
#(
   parameter int FEAT_W     = 64,
   parameter int STD_RSV_LO = 8,
   parameter int STD_RSV_HI = 23,
   parameter int CMP_RSV_LO = 16,
   parameter int CMP_RSV_HI = 63
)(
   input  logic [HDR_BITS-1:0] hdr_i,
   input  logic [FEAT_W-1:0]   feat_en_i,
   input  logic                cap_cmp_i,
   output hdr_flags_t          flags_o
);
   localparam int BM_W    = 64;
   localparam int FORM_B  = BM_W - 1;

   if (FEAT_W < 2 || FEAT_W > BM_W) begin : g_bad_feat
      $error("FEAT_W must lie in 2..64");
   end
   if (STD_RSV_HI >= HDR_BYTES || CMP_RSV_HI >= HDR_BYTES ||
       STD_RSV_LO > STD_RSV_HI || CMP_RSV_LO > CMP_RSV_HI) begin : g_bad_rsv
      $error("reserved byte window outside header");
   end

   logic [BM_W-1:0]      present, compact, feat64;
   logic [HDR_BYTES-1:0] byte_nz;
   logic                 form_cmp;

   assign present  = hdr_i[BM_W-1:0];
   assign compact  = hdr_i[2*BM_W-1:BM_W];
   assign form_cmp = compact[FORM_B];

   for (genvar i = 0; i < BM_W; i++) begin : g_feat
      if (i < FEAT_W) begin : g_in
         assign feat64[i] = feat_en_i[i];
      end else begin : g_out
         assign feat64[i] = 1'b0;
      end
   end

   for (genvar k = 0; k < HDR_BYTES; k++) begin : g_byte
      assign byte_nz[k] = |hdr_i[8*k +: 8];
   end

   always_comb begin
      flags_o       = '0;
      flags_o.nocmp = form_cmp & ~cap_cmp_i;
      if (!form_cmp) begin
         flags_o.spres = |(present & ~feat64);
         flags_o.srsv  = |byte_nz[STD_RSV_HI:STD_RSV_LO];
      end else begin
         flags_o.cbit  = |(compact[FORM_B-1:0] & ~feat64[FORM_B-1:0]);
         flags_o.corph = |(present & ~compact);
         flags_o.crsv  = |byte_nz[CMP_RSV_HI:CMP_RSV_LO];
      end
   end

   always_comb begin
      if (!$isunknown(hdr_i)) begin
         // the two form families never flag together
         p_form_exclusive_r8: assert (!((flags_o.spres | flags_o.srsv) &
                                        (flags_o.cbit | flags_o.corph | flags_o.crsv)))
            else $error("standard and compacted rules flagged together");
      end
   end
endmodule

// File: rtl/rsc_fault_select.sv
module rsc_fault_select
   import rstr_fault_pkg::*;
(
   input  logic               ud_i,
   input  logic [CAUSE_W-1:0] ud_cause_i,
   input  logic               nm_i,
   input  logic               misalign_i,
   input  hdr_flags_t         hflags_i,
   input  logic               csw_bad_i,
   output logic [3:0]         fault_o,
   output logic [CAUSE_W-1:0] cause_o
);
   logic [NHF-1:0] hvec;
   assign hvec = hflags_i;

   always_comb begin
      fault_o = FLT_GP;
      cause_o = C_NONE;
      if (ud_i) begin
         fault_o = FLT_UD;
         cause_o = ud_cause_i;
      end else if (nm_i) begin
         fault_o = FLT_NM;
         cause_o = C_NM_TS;
      end else if (misalign_i) begin
         cause_o = C_GP_ALIGN;
      end else if (|hvec) begin
         for (int j = NHF - 1; j >= 0; j--)
            if (hvec[j]) cause_o = C_GP_NOCMP + CAUSE_W'(j);
      end else if (csw_bad_i) begin
         cause_o = C_GP_CSW;
      end else begin
         fault_o = FLT_NONE;
      end
   end
endmodule

// File: rtl/rstr_fault_check.sv
module rstr_fault_check
   import rstr_fault_pkg::*;
#(
   parameter int ADDR_W      = 64,
   parameter int FEAT_W      = 64,
   parameter int CSW_W       = 32,
   parameter int ALIGN_BYTES = 64
)(
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic [HDR_BITS-1:0] hdr_i,
   input  logic [FEAT_W-1:0]   feat_en_i,
   input  logic                cap_save_i,
   input  logic                cap_cmp_i,
   input  logic                os_en_i,
   input  logic                task_sw_i,
   input  logic                lock_i,
   input  logic [CSW_W-1:0]    csw_i,
   input  logic [CSW_W-1:0]    csw_rsvd_i,
   output logic [3:0]          fault_o,
   output logic [CAUSE_W-1:0]  cause_o
);
   localparam int ALIGN_LSB = $clog2(ALIGN_BYTES);

   if (ALIGN_BYTES < 2 || (1 << ALIGN_LSB) != ALIGN_BYTES) begin : g_bad_align
      $error("ALIGN_BYTES must be a power of two");
   end
   if (ADDR_W <= ALIGN_LSB) begin : g_bad_addr
      $error("ADDR_W too small for alignment");
   end

   logic               ud, nm, misalign, csw_bad;
   logic [CAUSE_W-1:0] ud_cause;
   hdr_flags_t         hflags;

   assign misalign = |addr_i[ALIGN_LSB-1:0];
   assign csw_bad  = |(csw_i & csw_rsvd_i);

   rsc_access_check u_acc (
      .cap_save_i (cap_save_i),
      .os_en_i    (os_en_i),
      .lock_i     (lock_i),
      .task_sw_i  (task_sw_i),
      .ud_o       (ud),
      .ud_cause_o (ud_cause),
      .nm_o       (nm)
   );

   rsc_header_check #(.FEAT_W(FEAT_W)) u_hdr (
      .hdr_i     (hdr_i),
      .feat_en_i (feat_en_i),
      .cap_cmp_i (cap_cmp_i),
      .flags_o   (hflags)
   );

   rsc_fault_select u_sel (
      .ud_i       (ud),
      .ud_cause_i (ud_cause),
      .nm_i       (nm),
      .misalign_i (misalign),
      .hflags_i   (hflags),
      .csw_bad_i  (csw_bad),
      .fault_o    (fault_o),
      .cause_o    (cause_o)
   );

   always_comb begin
      if (!$isunknown({cap_save_i, os_en_i, lock_i, task_sw_i, addr_i, fault_o})) begin
         p_fault_onehot_r1: assert ($countones(fault_o) == 1)
            else $error("fault class not one-hot");
         p_none_cause_r1: assert ((fault_o == FLT_NONE) == (cause_o == C_NONE))
            else $error("cause disagrees with none class");
         p_ud_wins_r2: assert (!(!cap_save_i || !os_en_i || lock_i) || fault_o == FLT_UD)
            else $error("undefined-opcode condition not reported");
         p_nm_rank_r3: assert (!(cap_save_i && os_en_i && !lock_i && task_sw_i) ||
                               fault_o == FLT_NM)
            else $error("device-not-available condition not reported");
         p_align_first_r5: assert (!(fault_o == FLT_GP && misalign) || cause_o == C_GP_ALIGN)
            else $error("misalignment not ranked first");
      end
   end
endmodule

// File: tb/tb_rstr_fault_check.sv
module tb_rstr_fault_check;
   localparam logic [3:0] E_NONE = 4'b0001, E_GP = 4'b0010, E_UD = 4'b0100, E_NM = 4'b1000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [63:0]  addr;
   logic [511:0] hdr;
   logic [63:0]  feat;
   logic         cap_save, cap_cmp, os_en, ts, lock;
   logic [31:0]  csw, rsvd;
   logic [3:0]   fault, cause;

   int n_cmp = 0, n_bad = 0;

   rstr_fault_check dut (
      .addr_i(addr), .hdr_i(hdr), .feat_en_i(feat),
      .cap_save_i(cap_save), .cap_cmp_i(cap_cmp), .os_en_i(os_en),
      .task_sw_i(ts), .lock_i(lock), .csw_i(csw), .csw_rsvd_i(rsvd),
      .fault_o(fault), .cause_o(cause)
   );

   function automatic logic [7:0] model();
      logic [63:0] pres = hdr[63:0];
      logic [63:0] comp = hdr[127:64];
      if (!cap_save) return {E_UD, 4'd1};
      if (!os_en)    return {E_UD, 4'd2};
      if (lock)      return {E_UD, 4'd3};
      if (ts)        return {E_NM, 4'd4};
      if (addr[5:0] != 0) return {E_GP, 4'd5};
      if (comp[63] && !cap_cmp) return {E_GP, 4'd6};
      if (!comp[63]) begin
         if ((pres & ~feat) != 0)  return {E_GP, 4'd7};
         if (hdr[191:64] != 0)     return {E_GP, 4'd8};
      end else begin
         if ((comp[62:0] & ~feat[62:0]) != 0) return {E_GP, 4'd9};
         if ((pres & ~comp) != 0)  return {E_GP, 4'd10};
         if (hdr[511:128] != 0)    return {E_GP, 4'd11};
      end
      if ((csw & rsvd) != 0) return {E_GP, 4'd12};
      return {E_NONE, 4'd0};
   endfunction

   function automatic string req_of(input logic [3:0] c);
      case (c)
         0: return "R13"; 1,2,3: return "R2"; 4: return "R3"; 5: return "R5";
         6: return "R6"; 7: return "R7"; 8: return "R8"; 9: return "R9";
         10: return "R10"; 11: return "R11"; default: return "R12";
      endcase
   endfunction

   task automatic check(input string req);
      logic [7:0] e;
      #5;
      e = model();
      n_cmp++;
      if ({fault, cause} !== e) begin
         n_bad++;
         $display("FAIL %s: fault=%b cause=%0d expected fault=%b cause=%0d",
                  req, fault, cause, e[7:4], e[3:0]);
      end
      @(negedge clk);
   endtask

   task automatic set_valid_std();
      addr = 64'h1000; hdr = '0; feat = 64'h7;
      hdr[63:0] = 64'h5;
      cap_save = 1; cap_cmp = 1; os_en = 1; ts = 0; lock = 0;
      csw = 32'h1F80; rsvd = 32'hFFFF_0000;
   endtask

   task automatic set_valid_cmp();
      set_valid_std();
      hdr[127:64] = 64'h8000_0000_0000_0007;
      hdr[63:0]   = 64'h3;
   endtask

   initial begin
      #200000000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20241));
      set_valid_std();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1/R13: valid standard and compacted give none, cause 0
      set_valid_std(); check("R1 R13 std valid");
      set_valid_cmp(); check("R13 cmp valid");
      // R2 ordering
      set_valid_std(); cap_save = 0; os_en = 0; lock = 1; check("R2 nocap first");
      set_valid_std(); os_en = 0; lock = 1; ts = 1; check("R2 os before lock");
      set_valid_std(); lock = 1; ts = 1; addr = 64'h3; check("R2 lock over NM");
      // R3
      set_valid_std(); ts = 1; addr = 64'h8; check("R3 NM over GP");
      // R4 R5: misalign plus bad header
      set_valid_std(); addr = 64'h20; hdr[100] = 1; check("R4 R5 align first");
      // R6
      set_valid_cmp(); cap_cmp = 0; hdr[300] = 1; check("R6 no compact support");
      // R7 then R8 ranking
      set_valid_std(); hdr[10] = 1; hdr[70] = 1; check("R7 std present");
      set_valid_std(); hdr[191] = 1; check("R8 std byte 23");
      set_valid_std(); hdr[200] = 1; check("R8 std byte 25 ignored");
      // R9..R11
      set_valid_cmp(); hdr[64+40] = 1; check("R9 compact bit");
      set_valid_cmp(); hdr[5] = 1; check("R10 orphan present");
      set_valid_cmp(); hdr[511] = 1; check("R11 cmp byte 63");
      set_valid_cmp(); hdr[130] = 1; check("R11 cmp byte 16");
      // R12
      set_valid_std(); csw = 32'h0001_1F80; check("R12 reserved csw");
      set_valid_std(); hdr[70] = 1; csw = 32'h0001_0000; check("R8 over R12");

      for (int n = 0; n < 3000; n++) begin
         logic [31:0] r = $urandom;
         set_valid_std();
         feat = {$urandom, $urandom};
         hdr = '0;
         hdr[63:0] = {$urandom, $urandom} & feat;
         if (r[0]) begin
            hdr[127:64] = ({$urandom, $urandom} & feat) | 64'h8000_0000_0000_0000;
            hdr[63:0] = hdr[63:0] & hdr[127:64];
         end
         if (r[3:1] == 0) hdr[$urandom_range(511)] ^= 1'b1;
         if (r[5:4] == 0) hdr[$urandom_range(127)] ^= 1'b1;
         addr = {$urandom, $urandom};
         if (r[7:6] != 0) addr[5:0] = 0;
         cap_save = (r[11:8] != 0); os_en = (r[15:12] != 0);
         lock = (r[19:16] == 0); ts = (r[23:20] == 0);
         cap_cmp = (r[26:24] != 0);
         csw = $urandom; rsvd = (r[29:27] == 0) ? $urandom : 32'h0;
         begin
            logic [7:0] e = model();
            check({req_of(e[3:0]), " random"});
         end
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule